// File: doc/BRIEF.md
# Serial FPGA Configuration Loader

This block is the master side of a one-bit serial configuration link to a downstream FPGA. A one-cycle `start` launches a load of `byte_count` bytes. The loader asserts the target's program request and waits for the target to show init. It then releases program and waits for init to drop. After that it draws bytes from a valid/ready stream and shifts each one out on a data pin with a paced configuration clock.

The target samples the data pin on each rising clock edge. Before each byte the loader looks for the target's error indication, which is init active while done is still low. After the last byte it holds the data pin high and keeps clocking until done rises. Every waiting phase is bounded by one shared cycle counter. The outcome appears as a one-cycle end pulse and one of three sticky flags.

Top module: `serial_cfg_loader`

## Requirements
- R1: In idle, a high `start` at a clock edge raises `cfg_prog` and `busy` after that edge, latches `byte_count` and `half_period`, and clears all three result flags. A `start` while `busy` is high has no effect.
- R2: `cfg_prog` stays high until `init_act` is sampled high, and is then released. The loader then waits for `init_act` to be sampled low before it clocks any data. Each of these two waits ends in failure with `tmo_err` when TIMEOUT_CYCLES edges pass without the awaited level.
- R3: Exactly `byte_count` bytes are taken, one per `s_valid && s_ready` handshake. Each byte is sent as 8 bits, most significant bit first.
- R4: The sequence for each bit is fixed: `cfg_clk` goes low, then `cfg_data` takes the bit, then `cfg_clk` goes high. Successive pin changes are exactly H cycles apart, where H is the latched `half_period`, and a value of 0 is used as 1. `cfg_data` never changes while `cfg_clk` is high.
- R5: At each byte boundary, including the first, sampling `init_act`=1 with `done_in`=0 ends the load with `crc_err`. `s_ready` is low whenever that condition holds, so no further byte is accepted.
- R6: After the last byte, or straight after init clears when `byte_count` is 0, `cfg_data` is driven to 1. `cfg_clk` then toggles every H cycles. The load ends with `load_ok` at the first edge that samples `done_in`=1.
- R7: When `done_in` does not rise within TIMEOUT_CYCLES edges of entering the trailing-clock phase, the load ends with `tmo_err`.
- R8: Every load ends with `load_end` high for exactly one cycle, with `busy` and `cfg_prog` low. At most one of `load_ok`, `crc_err`, `tmo_err` is set, and it stays set until the next accepted `start`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a load (sampled in idle only) |
| byte_count | input | CNT_W | Number of bytes in the load |
| half_period | input | DIV_W | Cycles between pin changes (0 acts as 1) |
| s_valid | input | 1 | Byte stream valid |
| s_data | input | 8 | Byte stream data |
| s_ready | output | 1 | Byte stream ready |
| cfg_prog | output | 1 | Program request to target (1 = asserted) |
| cfg_clk | output | 1 | Configuration clock |
| cfg_data | output | 1 | Serial configuration data |
| init_act | input | 1 | Target init indication (1 = active) |
| done_in | input | 1 | Target done indication (1 = configured) |
| busy | output | 1 | Load in progress |
| load_end | output | 1 | One-cycle pulse when a load ends |
| load_ok | output | 1 | Sticky: last load finished with done |
| crc_err | output | 1 | Sticky: last load stopped on target error |
| tmo_err | output | 1 | Sticky: last load stopped on a timeout |

## Verification
The bench builds the loader with TIMEOUT_CYCLES of 40, a 4-bit divider and an 8-bit byte count. With those values, each of the three timeout exits is reached in a few dozen cycles, and the success path still finishes well inside the window. `half_period` is driven at 0, 1 and 3. This covers the zero-as-one rule and spacing wider than one cycle. An emulated target responds with chosen delays, holds init, stops answering, or raises the error condition after a chosen byte. Combined with a stalling byte source, this reaches every exit from every phase.

// File: rtl/cfgl_pkg.sv
package cfgl_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_WAIT_INIT,
        ST_WAIT_CLR,
        ST_BYTE,
        ST_BIT_DATA,
        ST_BIT_HIGH,
        ST_BIT_LOW,
        ST_TRAIL
    } ld_state_e;

    typedef enum logic [1:0] {
        RES_OK,
        RES_CRC,
        RES_TMO
    } ld_result_e;

endpackage

// File: rtl/cfgl_pace.sv
module cfgl_pace #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             load,
    input  logic [DIV_W-1:0] span,
    output logic             idle
);

    logic [DIV_W-1:0] pace_d, pace_q;

    always_comb begin
        pace_d = pace_q;
        if (clr) begin
            pace_d = '0;
        end else if (load) begin
            pace_d = span - 1'b1;
        end else if (pace_q != '0) begin
            pace_d = pace_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pace_q <= '0;
        else        pace_q <= pace_d;
    end

    assign idle = (pace_q == '0);

    // R4
    pace_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load && !clr) |=> (pace_q == $past(span) - 1'b1));

endmodule

// File: rtl/cfgl_timer.sv
module cfgl_timer #(
    parameter int TIMEOUT_CYCLES = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic inc,
    output logic hit
);

    localparam int TW = $clog2(TIMEOUT_CYCLES + 1);

    logic [TW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr)      cnt_d = '0;
        else if (inc) cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign hit = (cnt_q == TW'(TIMEOUT_CYCLES - 1));

    // R2
    wait_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q < TW'(TIMEOUT_CYCLES));

endmodule

// File: rtl/cfgl_shift.sv
module cfgl_shift
    import cfgl_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [BYTE_W-1:0] byte_in,
    input  logic              shift,
    output logic              msb,
    output logic              last
);

    localparam int IW = $clog2(BYTE_W);

    logic [BYTE_W-1:0] sr_d, sr_q;
    logic [IW-1:0]     idx_d, idx_q;

    always_comb begin
        sr_d  = sr_q;
        idx_d = idx_q;
        if (load) begin
            sr_d  = byte_in;
            idx_d = IW'(BYTE_W - 1);
        end else if (shift) begin
            sr_d  = {sr_q[BYTE_W-2:0], 1'b0};
            idx_d = idx_q - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sr_q  <= '0;
            idx_q <= '0;
        end else begin
            sr_q  <= sr_d;
            idx_q <= idx_d;
        end
    end

    assign msb  = sr_q[BYTE_W-1];
    assign last = (idx_q == '0);

    // R3
    msb_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (shift && !load) |=> (msb == $past(sr_q[BYTE_W-2])));

endmodule

// File: rtl/serial_cfg_loader.sv
module serial_cfg_loader
    import cfgl_pkg::*;
#(
    parameter int CNT_W          = 16,
    parameter int DIV_W          = 8,
    parameter int TIMEOUT_CYCLES = 1000000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [CNT_W-1:0]  byte_count,
    input  logic [DIV_W-1:0]  half_period,
    input  logic              s_valid,
    input  logic [BYTE_W-1:0] s_data,
    output logic              s_ready,
    output logic              cfg_prog,
    output logic              cfg_clk,
    output logic              cfg_data,
    input  logic              init_act,
    input  logic              done_in,
    output logic              busy,
    output logic              load_end,
    output logic              load_ok,
    output logic              crc_err,
    output logic              tmo_err
);

    typedef struct packed {
        ld_state_e        state;
        logic             prog;
        logic             sclk;
        logic             sdat;
        logic             busy;
        logic             fin;
        logic             ok;
        logic             crc;
        logic             tmo;
        logic [CNT_W-1:0] rem;
        logic [DIV_W-1:0] hp;
    } ctl_t;

    ctl_t ctl_d, ctl_q;

    logic tmr_clr, tmr_inc, tmr_hit;
    logic pace_clr, pace_load, pace_idle;
    logic sh_load, sh_shift, sh_msb, sh_last;
    logic tgt_fault;

    assign tgt_fault = init_act && !done_in;

    always_comb begin
        ctl_d     = ctl_q;
        ctl_d.fin = 1'b0;
        tmr_clr   = 1'b0;
        tmr_inc   = 1'b0;
        pace_clr  = 1'b0;
        pace_load = 1'b0;
        sh_load   = 1'b0;
        sh_shift  = 1'b0;
        s_ready   = 1'b0;

        unique case (ctl_q.state)
            ST_IDLE: begin
                if (start) begin
                    ctl_d.state = ST_WAIT_INIT;
                    ctl_d.prog  = 1'b1;
                    ctl_d.busy  = 1'b1;
                    ctl_d.ok    = 1'b0;
                    ctl_d.crc   = 1'b0;
                    ctl_d.tmo   = 1'b0;
                    ctl_d.rem   = byte_count;
                    ctl_d.hp    = (half_period == '0) ? DIV_W'(1) : half_period;
                    tmr_clr     = 1'b1;
                    pace_clr    = 1'b1;
                end
            end

            ST_WAIT_INIT: begin
                if (init_act) begin
                    ctl_d.prog  = 1'b0;
                    ctl_d.state = ST_WAIT_CLR;
                    tmr_clr     = 1'b1;
                end else if (tmr_hit) begin
                    ctl_d.state = ST_IDLE;
                    ctl_d.prog  = 1'b0;
                    ctl_d.busy  = 1'b0;
                    ctl_d.fin   = 1'b1;
                    ctl_d.tmo   = 1'b1;
                end else begin
                    tmr_inc = 1'b1;
                end
            end

            ST_WAIT_CLR: begin
                if (!init_act) begin
                    tmr_clr     = 1'b1;
                    ctl_d.state = (ctl_q.rem == '0) ? ST_TRAIL : ST_BYTE;
                end else if (tmr_hit) begin
                    ctl_d.state = ST_IDLE;
                    ctl_d.busy  = 1'b0;
                    ctl_d.fin   = 1'b1;
                    ctl_d.tmo   = 1'b1;
                end else begin
                    tmr_inc = 1'b1;
                end
            end

            ST_BYTE: begin
                if (pace_idle) begin
                    if (tgt_fault) begin
                        ctl_d.state = ST_IDLE;
                        ctl_d.busy  = 1'b0;
                        ctl_d.fin   = 1'b1;
                        ctl_d.crc   = 1'b1;
                    end else begin
                        s_ready = 1'b1;
                        if (s_valid) begin
                            sh_load     = 1'b1;
                            pace_load   = 1'b1;
                            ctl_d.rem   = ctl_q.rem - 1'b1;
                            ctl_d.sclk  = 1'b0;
                            ctl_d.state = ST_BIT_DATA;
                        end
                    end
                end
            end

            ST_BIT_DATA: begin
                if (pace_idle) begin
                    ctl_d.sdat  = sh_msb;
                    pace_load   = 1'b1;
                    ctl_d.state = ST_BIT_HIGH;
                end
            end

            ST_BIT_HIGH: begin
                if (pace_idle) begin
                    ctl_d.sclk = 1'b1;
                    pace_load  = 1'b1;
                    sh_shift   = 1'b1;
                    if (!sh_last) begin
                        ctl_d.state = ST_BIT_LOW;
                    end else if (ctl_q.rem == '0) begin
                        tmr_clr     = 1'b1;
                        ctl_d.state = ST_TRAIL;
                    end else begin
                        ctl_d.state = ST_BYTE;
                    end
                end
            end

            ST_BIT_LOW: begin
                if (pace_idle) begin
                    ctl_d.sclk  = 1'b0;
                    pace_load   = 1'b1;
                    ctl_d.state = ST_BIT_DATA;
                end
            end

            ST_TRAIL: begin
                if (done_in) begin
                    ctl_d.state = ST_IDLE;
                    ctl_d.busy  = 1'b0;
                    ctl_d.fin   = 1'b1;
                    ctl_d.ok    = 1'b1;
                end else if (tmr_hit) begin
                    ctl_d.state = ST_IDLE;
                    ctl_d.busy  = 1'b0;
                    ctl_d.fin   = 1'b1;
                    ctl_d.tmo   = 1'b1;
                end else begin
                    tmr_inc = 1'b1;
                    if (pace_idle) begin
                        pace_load = 1'b1;
                        if (ctl_q.sclk || !ctl_q.sdat) begin
                            ctl_d.sclk = 1'b0;
                            ctl_d.sdat = 1'b1;
                        end else begin
                            ctl_d.sclk = 1'b1;
                        end
                    end
                end
            end

            default: ctl_d.state = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q       <= '0;
            ctl_q.state <= ST_IDLE;
        end else begin
            ctl_q <= ctl_d;
        end
    end

    cfgl_timer #(
        .TIMEOUT_CYCLES(TIMEOUT_CYCLES)
    ) i_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (tmr_clr),
        .inc   (tmr_inc),
        .hit   (tmr_hit)
    );

    cfgl_pace #(
        .DIV_W(DIV_W)
    ) i_pace (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (pace_clr),
        .load  (pace_load),
        .span  (ctl_q.hp),
        .idle  (pace_idle)
    );

    cfgl_shift i_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (sh_load),
        .byte_in (s_data),
        .shift   (sh_shift),
        .msb     (sh_msb),
        .last    (sh_last)
    );

    assign cfg_prog = ctl_q.prog;
    assign cfg_clk  = ctl_q.sclk;
    assign cfg_data = ctl_q.sdat;
    assign busy     = ctl_q.busy;
    assign load_end = ctl_q.fin;
    assign load_ok  = ctl_q.ok;
    assign crc_err  = ctl_q.crc;
    assign tmo_err  = ctl_q.tmo;

    // R1
    prog_from_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_prog) |-> $past(start));

    // R4
    data_quiet_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(cfg_data) |-> !cfg_clk);

    // R4
    rise_data_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cfg_clk) |-> $stable(cfg_data));

    // R5
    crc_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(crc_err) |-> ($past(init_act) && !$past(done_in)));

    // R8
    one_result_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({load_ok, crc_err, tmo_err}));

    // R8
    end_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_end |=> !load_end);

    // R8
    end_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_end |-> (!busy && !cfg_prog));

endmodule

// File: tb/test_serial_cfg_loader.sv
`timescale 1ns/1ps
module test_serial_cfg_loader;

    localparam int CNT_W = 8;
    localparam int DIV_W = 4;
    localparam int TMO   = 40;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic [CNT_W-1:0] byte_count = '0;
    logic [DIV_W-1:0] half_period = '0;
    logic             s_valid = 1'b0;
    logic [7:0]       s_data = '0;
    logic             s_ready;
    logic             cfg_prog, cfg_clk, cfg_data;
    logic             init_act = 1'b0;
    logic             done_in = 1'b0;
    logic             busy, load_end, load_ok, crc_err, tmo_err;

    always #2.5 clk = ~clk;

    serial_cfg_loader #(
        .CNT_W(CNT_W), .DIV_W(DIV_W), .TIMEOUT_CYCLES(TMO)
    ) i_serial_cfg_loader (
        .clk(clk), .rst_n(rst_n), .start(start), .byte_count(byte_count),
        .half_period(half_period), .s_valid(s_valid), .s_data(s_data),
        .s_ready(s_ready), .cfg_prog(cfg_prog), .cfg_clk(cfg_clk),
        .cfg_data(cfg_data), .init_act(init_act), .done_in(done_in),
        .busy(busy), .load_end(load_end), .load_ok(load_ok),
        .crc_err(crc_err), .tmo_err(tmo_err)
    );

    int n_vec = 0;
    int n_bad = 0;

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual %0h expected %0h at %0t", req, what, act, exp, $time);
        end
    endtask

    // ---------------- byte source ----------------
    logic [7:0] src_q[$];
    logic       stall_mode = 1'b0;
    logic       hs_seen = 1'b0;
    int         cyc = 0;

    always @(negedge clk) hs_seen <= s_valid && s_ready;

    always @(posedge clk) begin
        #1;
        cyc++;
        if (hs_seen && src_q.size() > 0) void'(src_q.pop_front());
        s_valid = (src_q.size() > 0) && !(stall_mode && (cyc % 5 == 3));
        s_data  = (src_q.size() > 0) ? src_q[0] : 8'h00;
    end

    // ---------------- emulated target ----------------
    int  m_init_dly = 2, m_clr_dly = 2, m_crc_after = -1, m_trail = 4, m_nbytes = 0;
    bit  m_no_init = 0, m_hold_init = 0, m_no_done = 0;
    int  ph = 0, icnt = 0, bits = 0, tcount = 0;
    logic [7:0] sr = 8'h00;
    logic prev_clk = 1'b0;
    logic [7:0] got_q[$];

    always @(posedge clk) begin
        #1;
        if (cfg_prog) begin
            if (ph != 1) begin
                ph = 1; icnt = 0; init_act = 1'b0; done_in = 1'b0; bits = 0; tcount = 0;
            end else begin
                icnt++;
            end
            if (!m_no_init && icnt >= m_init_dly) init_act = 1'b1;
        end else if (ph == 1) begin
            ph = 2; icnt = 0;
        end else if (ph == 2) begin
            if (!m_hold_init) begin
                icnt++;
                if (icnt >= m_clr_dly) begin init_act = 1'b0; ph = 3; end
            end
        end else if (ph == 3 && cfg_clk && !prev_clk) begin
            if (bits < m_nbytes * 8) begin
                sr = {sr[6:0], cfg_data};
                bits++;
                if (bits % 8 == 0) got_q.push_back(sr);
                if (m_crc_after >= 0 && bits == m_crc_after * 8) init_act = 1'b1;
            end else begin
                chk("R6", "data level on trailing clock", 32'(cfg_data), 32'd1);
                tcount++;
                if (!m_no_done && tcount >= m_trail) done_in = 1'b1;
            end
        end
        prev_clk = cfg_clk;
    end

    // ---------------- reference model ----------------
    logic e_prog = 0, e_clk = 0, e_dat = 0, e_busy = 0, e_fin = 0;
    logic e_ok = 0, e_crc = 0, e_tmo = 0, e_win = 0;
    int   m_h = 1;

    task automatic m_finish(input int kind);
        e_busy = 0; e_prog = 0; e_fin = 1; e_win = 0;
        if (kind == 0) e_ok = 1;
        if (kind == 1) e_crc = 1;
        if (kind == 2) e_tmo = 1;
    endtask

    task automatic m_gap();
        repeat (m_h - 1) @(posedge clk);
        @(posedge clk);
    endtask

    task automatic m_load();
        int rem, t, p;
        logic [7:0] b;
        e_prog = 1; e_busy = 1; e_ok = 0; e_crc = 0; e_tmo = 0;
        rem = int'(byte_count);
        m_h = (half_period == 0) ? 1 : int'(half_period);
        t = 0;
        forever begin
            @(posedge clk); e_fin = 0;
            if (init_act) begin e_prog = 0; break; end
            if (t == TMO - 1) begin m_finish(2); return; end
            t++;
        end
        t = 0;
        forever begin
            @(posedge clk);
            if (!init_act) break;
            if (t == TMO - 1) begin m_finish(2); return; end
            t++;
        end
        p = 0;
        while (rem > 0) begin
            repeat (p) @(posedge clk);
            e_win = 1;
            forever begin
                @(posedge clk);
                if (init_act && !done_in) begin m_finish(1); return; end
                if (s_valid) begin b = s_data; break; end
            end
            e_win = 0; rem--; e_clk = 0;
            for (int k = 7; k >= 0; k--) begin
                m_gap(); e_dat = b[k];
                m_gap(); e_clk = 1;
                if (k > 0) begin m_gap(); e_clk = 0; end
            end
            p = m_h - 1;
        end
        t = 0;
        forever begin
            @(posedge clk);
            if (done_in) begin m_finish(0); return; end
            if (t == TMO - 1) begin m_finish(2); return; end
            t++;
            if (p == 0) begin
                if (e_clk || !e_dat) begin e_clk = 0; e_dat = 1; end
                else e_clk = 1;
                p = m_h - 1;
            end else begin
                p--;
            end
        end
    endtask

    initial begin
        @(posedge rst_n);
        forever begin
            @(posedge clk);
            e_fin = 0;
            if (start) m_load();
        end
    end

    // ---------------- per-cycle comparison ----------------
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R1", "cfg_prog", 32'(cfg_prog), 32'(e_prog));
            chk("R4", "cfg_clk", 32'(cfg_clk), 32'(e_clk));
            chk("R3", "cfg_data", 32'(cfg_data), 32'(e_dat));
            chk("R1", "busy", 32'(busy), 32'(e_busy));
            chk("R8", "load_end", 32'(load_end), 32'(e_fin));
            chk("R6", "load_ok", 32'(load_ok), 32'(e_ok));
            chk("R5", "crc_err", 32'(crc_err), 32'(e_crc));
            chk("R7", "tmo_err", 32'(tmo_err), 32'(e_tmo));
            chk("R5", "s_ready", 32'(s_ready), 32'(e_win && !(init_act && !done_in)));
        end
    end

    // ---------------- scenarios ----------------
    task automatic pulse_start();
        @(posedge clk); #1 start = 1'b1;
        @(posedge clk); #1 start = 1'b0;
    endtask

    task automatic wait_end();
        int w = 0;
        @(negedge clk);
        while (!load_end && w < 5000) begin @(negedge clk); w++; end
        if (w >= 5000) chk("R8", "load end reached", 32'd0, 32'd1);
        repeat (3) @(negedge clk);
    endtask

    task automatic run_case(input int n, input int h, input string req,
                            input logic exp_ok, input logic exp_crc, input logic exp_tmo);
        logic [7:0] sent[$];
        sent = {};
        got_q = {};
        for (int i = 0; i < n; i++) begin
            sent.push_back(8'((i * 8'h5b + 8'h96) ^ (h << 4)));
            src_q.push_back(sent[i]);
        end
        m_nbytes = n;
        byte_count = CNT_W'(n);
        half_period = DIV_W'(h);
        pulse_start();
        wait_end();
        chk(req, "load_ok result", 32'(load_ok), 32'(exp_ok));
        chk(req, "crc_err result", 32'(crc_err), 32'(exp_crc));
        chk(req, "tmo_err result", 32'(tmo_err), 32'(exp_tmo));
        if (exp_ok) begin
            chk("R3", "bytes captured", 32'(got_q.size()), 32'(n));
            for (int i = 0; i < got_q.size() && i < n; i++)
                chk("R3", "captured byte", 32'(got_q[i]), 32'(sent[i]));
        end
        src_q = {};
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk("R8", "reset busy", 32'(busy), 32'd0);
        chk("R1", "reset cfg_prog", 32'(cfg_prog), 32'd0);
        chk("R8", "reset flags", 32'({load_ok, crc_err, tmo_err}), 32'd0);

        // R3 R4 R6: three bytes, one-cycle spacing, stalling source
        stall_mode = 1'b1;
        run_case(3, 1, "R6", 1'b1, 1'b0, 1'b0);

        // R4: wider spacing, start pulse while busy ignored (R1)
        stall_mode = 1'b0; m_init_dly = 5; m_clr_dly = 4;
        fork
            run_case(2, 3, "R6", 1'b1, 1'b0, 1'b0);
            begin repeat (40) @(posedge clk); #1 start = 1'b1; @(posedge clk); #1 start = 1'b0; end
        join

        // R4: half_period 0 acts as 1
        m_init_dly = 1; m_clr_dly = 1;
        run_case(1, 0, "R4", 1'b1, 1'b0, 1'b0);

        // R6: zero bytes goes straight to trailing clocks
        run_case(0, 2, "R6", 1'b1, 1'b0, 1'b0);

        // R2: target never shows init
        m_no_init = 1;
        run_case(2, 1, "R2", 1'b0, 1'b0, 1'b1);
        m_no_init = 0;

        // R2: init never clears
        m_hold_init = 1;
        run_case(2, 1, "R2", 1'b0, 1'b0, 1'b1);
        m_hold_init = 0;

        // R5: error raised after first byte; remaining bytes not taken
        m_crc_after = 1;
        run_case(3, 1, "R5", 1'b0, 1'b1, 1'b0);
        chk("R5", "bytes accepted before error", 32'(got_q.size()), 32'd1);
        m_crc_after = -1;

        // R7: done never rises
        m_no_done = 1;
        run_case(1, 1, "R7", 1'b0, 1'b0, 1'b1);
        m_no_done = 0;

        // R8: flags cleared on next start, clean success after failures
        run_case(2, 2, "R8", 1'b1, 1'b0, 1'b0);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 5);
        n_vec++; n_bad++;
        $display("FAIL R8 watchdog expired actual 0 expected 1");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule